// File: doc/BRIEF.md
# Line-Duty Sync Presence Detector

This block decides whether a composite video input carries line sync. Its input is the one-bit output of an analog slicer that is high while the clamped video sits above the slice level and low during sync tips. The signal is first brought into the sample clock domain. Every line is then measured from one falling edge to the next, and the block counts how many of that line's samples were high. The high fraction of the line is tested against two thresholds. A line at or above the upper threshold counts as a good sync line. A line at or below the lower threshold counts as a bad one. A line between the two has no effect, which gives the decision its hysteresis.

A good line loads a hold counter with a line budget. Every bad line, and every stretch of 1.5 nominal line periods with no falling edge, spends one unit of that budget. The sync-present flag is high while budget remains. This keeps the flag steady across short dropouts. A flat input produces no edges and so never raises the flag. The flag is also placed at bit 5 of an 8-bit status byte that a control interface reads.

Top module: `sync_duty_detect`

## Requirements
- R1: During and directly after reset, `sync_present` is 0, `status_byte` is 8'h00 and the hold budget is empty.
- R2: A line runs from one falling edge of the synchronized input to the next. The first falling edge after reset, or after a timeout, only opens a line and never produces a verdict.
- R3: A line whose high sample count H and length P satisfy H*100 >= ON_PCT*P (default 91) is good. It reloads the budget to HOLD_LINES and sets `sync_present`. The first complete good line after reset sets the flag.
- R4: A line with H*100 <= OFF_PCT*P (default 84) is bad. It lowers a non-empty budget by one.
- R5: A line strictly between the two thresholds leaves both the budget and the flag unchanged, whether the flag is set or clear.
- R6: Once set, `sync_present` stays high until HOLD_LINES bad lines have been counted since the last good line. Lines inside the band in between neither extend nor shorten the hold.
- R7: When no falling edge arrives within TMO = NOM_LINE + NOM_LINE/2 samples, this counts as one bad line, and the block waits for a new opening edge. A constant input therefore clears a set flag after HOLD_LINES such timeouts.
- R8: `status_byte` has the flag at bit 5 and zeros in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_hi | input | 1 | Slicer output, high above the slice level, asynchronous |
| sync_present | output | 1 | Sync-present decision |
| status_byte | output | 8 | Status byte with the decision at bit 5 |

## Verification
The bench sweeps the sync-tip width one sample at a time at four line lengths. Each sweep crosses both thresholds, so the good, band and bad verdicts are separated at their exact integer boundaries. Because the sweep runs as one continuous sequence, band lines are seen from both a set and a cleared flag. A run of bad lines interleaved with a band line separates hold counting from a plain reset-on-bad scheme. A long constant-high stretch checks the timeout count and the rule that the first edge afterwards only opens a line.

// File: rtl/sync_duty_pkg.sv
package sync_duty_pkg;
   typedef enum logic [1:0] {
      V_NONE = 2'd0,
      V_GOOD = 2'd1,
      V_BAD  = 2'd2
   } line_verdict_t;
endpackage

// File: rtl/sync_edge_in.sv
module sync_edge_in #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl_o,
   output logic fall_o
);
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign lvl_o = din;
      end else begin : g_chain
         logic [STAGES-1:0] st_q;
         for (genvar i = 0; i < STAGES; i++) begin : g_st
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) st_q[i] <= 1'b1;
               else if (i == 0) st_q[i] <= din;
               else st_q[i] <= st_q[(i == 0) ? 0 : i-1];
            end
         end
         assign lvl_o = st_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else prev_q <= lvl_o;
   end

   assign fall_o = prev_q & ~lvl_o;
endmodule

// File: rtl/sync_line_meter.sv
module sync_line_meter
   import sync_duty_pkg::*;
#(
   parameter int TMO     = 150,
   parameter int ON_PCT  = 91,
   parameter int OFF_PCT = 84,
   localparam int CW     = $clog2(TMO + 1),
   localparam int PW     = CW + 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lvl_i,
   input  logic          fall_i,
   output line_verdict_t verdict_o,
   output logic [CW-1:0] len_o
);
   logic          framed_q;
   logic [CW-1:0] per_q;
   logic [CW-1:0] hi_q;
   line_verdict_t verdict_q;
   logic [PW-1:0] hi_scaled, on_lim, off_lim;
   logic          is_good, is_bad, timed_out;

   assign hi_scaled = PW'(hi_q) * PW'(100);
   assign on_lim    = PW'(per_q) * PW'(ON_PCT);
   assign off_lim   = PW'(per_q) * PW'(OFF_PCT);
   assign is_good   = (hi_scaled >= on_lim);
   assign is_bad    = (hi_scaled <= off_lim);
   assign timed_out = (per_q >= CW'(TMO));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         framed_q  <= 1'b0;
         per_q     <= '0;
         hi_q      <= '0;
         verdict_q <= V_NONE;
      end else begin
         verdict_q <= V_NONE;
         if (fall_i) begin
            if (framed_q) begin
               if (is_good) verdict_q <= V_GOOD;
               else if (is_bad) verdict_q <= V_BAD;
            end
            framed_q <= 1'b1;
            per_q    <= CW'(1);
            hi_q     <= '0;
         end else if (timed_out) begin
            verdict_q <= V_BAD;
            framed_q  <= 1'b0;
            per_q     <= CW'(1);
            hi_q      <= CW'(lvl_i);
         end else begin
            per_q <= per_q + CW'(1);
            hi_q  <= hi_q + CW'(lvl_i);
         end
      end
   end

   assign verdict_o = verdict_q;
   assign len_o     = per_q;
endmodule

// File: rtl/sync_hold_ctr.sv
module sync_hold_ctr
   import sync_duty_pkg::*;
#(
   parameter int HOLD_LINES = 14,
   localparam int HW        = $clog2(HOLD_LINES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  line_verdict_t verdict_i,
   output logic [HW-1:0] cnt_o,
   output logic          flag_o
);
   logic [HW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (verdict_i == V_GOOD) cnt_q <= HW'(HOLD_LINES);
      else if (verdict_i == V_BAD && cnt_q != '0) cnt_q <= cnt_q - HW'(1);
   end

   assign cnt_o  = cnt_q;
   assign flag_o = (cnt_q != '0);
endmodule

// File: rtl/sync_duty_detect.sv
module sync_duty_detect
   import sync_duty_pkg::*;
#(
   parameter int NOM_LINE    = 6356,
   parameter int ON_PCT      = 91,
   parameter int OFF_PCT     = 84,
   parameter int HOLD_LINES  = 14,
   parameter int SYNC_STAGES = 2,
   parameter int FLAG_POS    = 5,
   localparam int TMO        = NOM_LINE + NOM_LINE / 2,
   localparam int CW         = $clog2(TMO + 1),
   localparam int HW         = $clog2(HOLD_LINES + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slice_hi,
   output logic       sync_present,
   output logic [7:0] status_byte
);
   generate
      if (NOM_LINE < 8) begin : g_bad_nom
         $error("NOM_LINE too small");
      end
      if (OFF_PCT >= ON_PCT || ON_PCT > 100 || OFF_PCT < 1) begin : g_bad_pct
         $error("threshold percentages out of order");
      end
      if (HOLD_LINES < 1) begin : g_bad_hold
         $error("HOLD_LINES must be at least 1");
      end
      if (FLAG_POS < 0 || FLAG_POS > 7) begin : g_bad_pos
         $error("FLAG_POS outside the status byte");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES out of range");
      end
   endgenerate

   logic          lvl, fall;
   line_verdict_t verdict;
   logic [CW-1:0] line_len;
   logic [HW-1:0] hold_cnt;
   logic          flag;

   sync_edge_in #(.STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (slice_hi),
      .lvl_o  (lvl),
      .fall_o (fall)
   );

   sync_line_meter #(.TMO(TMO), .ON_PCT(ON_PCT), .OFF_PCT(OFF_PCT)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_i     (lvl),
      .fall_i    (fall),
      .verdict_o (verdict),
      .len_o     (line_len)
   );

   sync_hold_ctr #(.HOLD_LINES(HOLD_LINES)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .verdict_i (verdict),
      .cnt_o     (hold_cnt),
      .flag_o    (flag)
   );

   assign sync_present = flag;

   always_comb begin
      status_byte           = '0;
      status_byte[FLAG_POS] = flag;
   end
endmodule

// File: rtl/sync_duty_detect_chk.sv
module sync_duty_detect_chk
   import sync_duty_pkg::*;
#(
   parameter int HOLD_LINES = 14,
   parameter int TMO_CYC    = 150,
   parameter int CW         = 8,
   parameter int HW         = 4
) (
   input logic          clk,
   input logic          rst_n,
   input line_verdict_t verdict,
   input logic [CW-1:0] line_len,
   input logic [HW-1:0] hold_cnt,
   input logic          flag,
   input logic [7:0]    status
);
   // R1: reset empties the hold budget
   a_r1_reset_empty: assert property (@(posedge clk)
      !rst_n |=> (hold_cnt == '0));

   // R3: a good line reloads the full budget
   a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict == V_GOOD) |=> (hold_cnt == HW'(HOLD_LINES)));

   // R3: the flag only rises after a good line
   a_r3_rise_after_good: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(verdict) == V_GOOD));

   // R4: the flag only falls after a bad line
   a_r4_fall_after_bad: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> ($past(verdict) == V_BAD));

   // R5: without a verdict the budget stays put
   a_r5_no_verdict_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict == V_NONE) |=> $stable(hold_cnt));

   // R6: budget never exceeds the hold length
   a_r6_budget_bound: assert property (@(posedge clk) disable iff (!rst_n)
      hold_cnt <= HW'(HOLD_LINES));

   // R7: line length never runs past the timeout window
   a_r7_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      line_len <= CW'(TMO_CYC));

   // R8: at most one status bit is set
   a_r8_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(status));
endmodule

bind sync_duty_detect sync_duty_detect_chk #(
   .HOLD_LINES (HOLD_LINES),
   .TMO_CYC    (TMO),
   .CW         (CW),
   .HW         (HW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .verdict  (verdict),
   .line_len (line_len),
   .hold_cnt (hold_cnt),
   .flag     (flag),
   .status   (status_byte)
);

// File: tb/sim_sync_duty_detect.sv
module sim_sync_duty_detect;
   localparam int CLK_PERIOD = 10;
   localparam int NOM   = 100;
   localparam int HOLD  = 4;
   localparam int ON_P  = 91;
   localparam int OFF_P = 84;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slice_in = 1'b1;
   logic       flag;
   logic [7:0] stat;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 0;

   // reference state, derived from the requirements
   int    m_cnt = 0;
   bit    m_framed = 0;
   int    m_p = 0;
   int    m_l = 0;
   string m_last = "R2";

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_duty_detect #(
      .NOM_LINE(NOM), .ON_PCT(ON_P), .OFF_PCT(OFF_P),
      .HOLD_LINES(HOLD), .SYNC_STAGES(2), .FLAG_POS(5)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .slice_hi(slice_in),
      .sync_present(flag), .status_byte(stat)
   );

   task automatic check_out(input bit exp, input string tag);
      total++;
      if (flag !== exp) begin
         bad++;
         $display("FAIL %s flag: actual=%0b expected=%0b (t=%0t)", tag, flag, exp, $time);
      end
      total++;
      if (stat !== (exp ? 8'h20 : 8'h00)) begin
         bad++;
         $display("FAIL R8 status: actual=%h expected=%h", stat, exp ? 8'h20 : 8'h00);
      end
   endtask

   task automatic eval_prev();
      int h = m_p - m_l;
      if (h * 100 >= ON_P * m_p) begin
         m_cnt = HOLD; m_last = "R3";
      end else if (h * 100 <= OFF_P * m_p) begin
         if (m_cnt > 0) m_cnt--;
         m_last = "R4";
      end else begin
         m_last = "R5";
      end
   endtask

   // one line: low for lw samples, then high; sampled near its end
   task automatic run_line(input int p, input int lw, input string tag);
      if (m_framed) eval_prev();
      else m_last = "R2";
      m_framed = 1; m_p = p; m_l = lw;
      for (int c = 0; c < p; c++) begin
         @(negedge clk);
         if (c == p - 3) check_out(m_cnt != 0, (tag == "") ? m_last : tag);
         slice_in = (c < lw) ? 1'b0 : 1'b1;
      end
   endtask

   task automatic hold_high(input int n);
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         slice_in = 1'b1;
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check_out(1'b0, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_out(1'b0, "R1");

      // R2 then R3: first edge only opens, first full good line sets
      run_line(100, 5, "R2");
      run_line(100, 5, "R3");

      // duty sweeps at several line lengths (R3, R4, R5 by category)
      foreach (sweep_p[i]) begin
         for (int lw = 1; lw <= sweep_p[i] / 5; lw++) begin
            run_line(sweep_p[i], lw, "");
            run_line(sweep_p[i], lw, "");
         end
      end

      // R6: hold budget across bad lines with a band line in between
      run_line(100, 5, "");
      run_line(100, 5, "R6");
      for (int k = 0; k < HOLD - 1; k++) run_line(100, 30, "R6");
      run_line(100, 12, "R6");
      run_line(100, 30, "R6");
      run_line(100, 5, "R6");
      total++;
      if (m_cnt != 0) begin
         bad++;
         $display("FAIL R6 model: actual=%0d expected=0", m_cnt);
      end

      // R7: constant high input times out HOLD times
      run_line(100, 5, "");
      run_line(100, 5, "R7");
      run_line(100, 5, "R7");
      hold_high(490);
      check_out(1'b1, "R7");
      hold_high(30);
      check_out(1'b0, "R7");
      m_cnt = 0; m_framed = 0;

      // R2 after timeout: first edge only opens
      run_line(100, 5, "R2");
      run_line(100, 5, "R3");
      run_line(100, 5, "R3");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   int sweep_p [4] = '{80, 100, 120, 140};
endmodule